// File: doc/BRIEF.md
# Grouped compare latch loader

This block holds the double-buffered compare values for a bank of seven timer compare channels. Each channel owns a software-written compare register and a shadow latch; the comparator downstream sees only the latch. A two-bit load-event code per channel chooses the moment at which the register is copied into the latch. Choices are: at once on a register write, when the counter hits zero, at the counter's turning points, or when the counter equals the latch itself.

A two-bit grouping code can gang the latches so that several channels refresh on the very same clock edge. Within a group only one leader channel's load-event code and event matter. The counter, its period logic and the output waveform stages sit outside; they feed this block with single-cycle event strobes, the current count and the counting mode.

Top module: `cmp_latch_loader`

## Requirements
- R1: While `rst` is high at a clock edge, every compare register and every latch is cleared to zero.
- R2: Load-event code 0 (`ld_sel` bits [2i+1:2i] of the leader) loads the latch on the clock edge where the leader's register is written; a written channel's latch then shows `wr_data` one cycle after the write.
- R3: Load-event code 1 loads the latches on an edge where `cnt_zero` is high.
- R4: Load-event code 2 with `updown` low loads only when `cnt_zero` is high; a `cnt_period` strobe alone causes no load.
- R5: Load-event code 2 with `updown` high loads when either `cnt_zero` or `cnt_period` is high.
- R6: Load-event code 3 loads when `cnt_value` equals the leader channel's current latch value.
- R7: Group code 0 lets every channel load by its own code and events.
- R8: Group code 1 joins channels 1 and 2, 3 and 4, 5 and 6, led by channels 1, 3 and 5; channel 0 stays on its own.
- R9: Group code 2 joins channels 1 to 3 and 4 to 6, led by channels 1 and 4; channel 0 stays on its own.
- R10: Group code 3 joins all channels 0 to 6 under the code and latch of channel 1.
- R11: Without a load event for its group, a latch keeps its value, whatever is written to the registers.
- R12: If a register write and a load event fall in the same cycle, the latch takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 3 | Channel index of the write |
| wr_data | input | 16 | Value written to the compare register |
| ld_sel | input | 14 | Load-event code per channel, two bits each, channel 0 in the lowest bits |
| grp_sel | input | 2 | Grouping code (0 none, 1 pairs, 2 triplets, 3 all) |
| updown | input | 1 | High while the counter runs in up/down mode |
| cnt_zero | input | 1 | Counter is at zero this cycle |
| cnt_period | input | 1 | Counter is at the period value this cycle |
| cnt_value | input | 16 | Current counter value |
| latch_o | output | 112 | All latch values, channel i at bits [16i+15:16i] |

## Verification
The assertions assume only that every input holds a known value at each clock edge after reset and that `wr_sel` names an existing channel when `wr_en` is high. They do not assume the event strobes come from a real counter, so zero, period and match strobes may coincide or arrive in any order. The stimulus drives those strobes independently of one another, a superset of what a counter could produce, and draws data and counter values from a small range so that match loads actually occur.

// File: rtl/cll_pkg.sv
package cll_pkg;

  typedef enum logic [1:0] {
    LD_ON_WRITE = 2'd0,
    LD_AT_ZERO  = 2'd1,
    LD_AT_ENDS  = 2'd2,
    LD_AT_MATCH = 2'd3
  } ld_evt_e;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_PAIR = 2'd1,
    GRP_TRIO = 2'd2,
    GRP_ALL  = 2'd3
  } grp_e;

  // Index of the channel whose event drives channel ch under grouping g.
  function automatic int unsigned leader_of(grp_e g, int unsigned ch);
    int unsigned r;
    case (g)
      GRP_PAIR: r = (ch == 0) ? 0 : ((ch - 1) / 2) * 2 + 1;
      GRP_TRIO: r = (ch == 0) ? 0 : ((ch - 1) / 3) * 3 + 1;
      GRP_ALL:  r = 1;
      default:  r = ch;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cll_evt_gen.sv
module cll_evt_gen
  import cll_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ld_evt_e       mode,
  input  logic          wr_hit,
  input  logic          updown,
  input  logic          cnt_zero,
  input  logic          cnt_period,
  input  logic [W-1:0]  cnt_value,
  input  logic [W-1:0]  latch_cur,
  output logic          evt
);

  always_comb begin
    case (mode)
      LD_ON_WRITE: evt = wr_hit;
      LD_AT_ZERO:  evt = cnt_zero;
      LD_AT_ENDS:  evt = cnt_zero | (updown & cnt_period);
      default:     evt = (cnt_value == latch_cur);
    endcase
  end

  // R3 R4 R5
  property no_strobe_no_evt_p;
    @(posedge clk) disable iff (rst)
      ((mode == LD_AT_ZERO || mode == LD_AT_ENDS) && !cnt_zero && !cnt_period) |-> !evt;
  endproperty
  no_strobe_no_evt_chk: assert property (no_strobe_no_evt_p);

  // R4
  property period_ignored_up_p;
    @(posedge clk) disable iff (rst)
      (mode == LD_AT_ENDS && !updown && !cnt_zero) |-> !evt;
  endproperty
  period_ignored_up_chk: assert property (period_ignored_up_p);

endmodule

// File: rtl/cll_group_route.sv
module cll_group_route
  import cll_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  grp_e           grp,
  input  logic [NCH-1:0] evt,
  output logic [NCH-1:0] ld_go
);

  for (genvar i = 0; i < NCH; i++) begin : g_route
    always_comb ld_go[i] = evt[leader_of(grp, i)];
  end

  // R8
  property pair_lockstep_p;
    @(posedge clk) disable iff (rst)
      (grp == GRP_PAIR) |-> (ld_go[1] == ld_go[2]);
  endproperty
  pair_lockstep_chk: assert property (pair_lockstep_p);

  // R9
  property trio_lockstep_p;
    @(posedge clk) disable iff (rst)
      (grp == GRP_TRIO) |-> (ld_go[4] == ld_go[5] && ld_go[5] == ld_go[6]);
  endproperty
  trio_lockstep_chk: assert property (trio_lockstep_p);

  // R10
  property all_lockstep_p;
    @(posedge clk) disable iff (rst)
      (grp == GRP_ALL) |-> (ld_go == '0 || ld_go == '1);
  endproperty
  all_lockstep_chk: assert property (all_lockstep_p);

endmodule

// File: rtl/cll_chan.sv
module cll_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         ld_go,
  output logic [W-1:0] latch_q
);

  logic [W-1:0] creg_q;
  logic [W-1:0] eff;

  // A write landing in the same cycle as a load is forwarded to the latch.
  always_comb eff = wr_hit ? wr_data : creg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      creg_q  <= '0;
      latch_q <= '0;
    end else begin
      if (wr_hit) creg_q <= wr_data;
      if (ld_go)  latch_q <= eff;
    end
  end

  // R12
  property fwd_write_p;
    @(posedge clk) disable iff (rst)
      (ld_go && wr_hit) |=> (latch_q == creg_q);
  endproperty
  fwd_write_chk: assert property (fwd_write_p);

  // R11
  property hold_p;
    @(posedge clk) disable iff (rst)
      !ld_go |=> $stable(latch_q);
  endproperty
  hold_chk: assert property (hold_p);

endmodule

// File: rtl/cmp_latch_loader.sv
module cmp_latch_loader
  import cll_pkg::*;
#(
  parameter  int NCH  = 7,
  parameter  int W    = 16,
  localparam int SELW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SELW-1:0]  wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [2*NCH-1:0] ld_sel,
  input  logic [1:0]       grp_sel,
  input  logic             updown,
  input  logic             cnt_zero,
  input  logic             cnt_period,
  input  logic [W-1:0]     cnt_value,
  output logic [NCH*W-1:0] latch_o
);

  logic [NCH-1:0] wr_hit;
  logic [NCH-1:0] evt;
  logic [NCH-1:0] ld_go;
  logic [W-1:0]   lat [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb wr_hit[i] = wr_en && (wr_sel == SELW'(i));

    cll_evt_gen #(.W(W)) u_evt (
      .clk        (clk),
      .rst        (rst),
      .mode       (ld_evt_e'(ld_sel[2*i +: 2])),
      .wr_hit     (wr_hit[i]),
      .updown     (updown),
      .cnt_zero   (cnt_zero),
      .cnt_period (cnt_period),
      .cnt_value  (cnt_value),
      .latch_cur  (lat[i]),
      .evt        (evt[i])
    );

    cll_chan #(.W(W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit[i]),
      .wr_data (wr_data),
      .ld_go   (ld_go[i]),
      .latch_q (lat[i])
    );

    always_comb latch_o[i*W +: W] = lat[i];
  end

  cll_group_route #(.NCH(NCH)) u_route (
    .clk   (clk),
    .rst   (rst),
    .grp   (grp_e'(grp_sel)),
    .evt   (evt),
    .ld_go (ld_go)
  );

  // R1
  property reset_clear_p;
    @(posedge clk) rst |=> (latch_o == '0);
  endproperty
  reset_clear_chk: assert property (reset_clear_p);

  // R7
  property indep_ch0_p;
    @(posedge clk) disable iff (rst)
      (grp_sel != 2'd3 && ld_sel[1:0] == 2'd1 && !cnt_zero) |=> $stable(latch_o[W-1:0]);
  endproperty
  indep_ch0_chk: assert property (indep_ch0_p);

endmodule

// File: tb/cmp_latch_loader_tb_top.sv
module cmp_latch_loader_tb_top;
  localparam int NCH = 7;
  localparam int W   = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst;
  logic             wr_en;
  logic [2:0]       wr_sel;
  logic [W-1:0]     wr_data;
  logic [2*NCH-1:0] ld_sel;
  logic [1:0]       grp_sel;
  logic             updown, cnt_zero, cnt_period;
  logic [W-1:0]     cnt_value;
  logic [NCH*W-1:0] latch_o;

  cmp_latch_loader dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ld_sel(ld_sel), .grp_sel(grp_sel), .updown(updown), .cnt_zero(cnt_zero),
    .cnt_period(cnt_period), .cnt_value(cnt_value), .latch_o(latch_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] reg_m [NCH];
  logic [W-1:0] lat_m [NCH];

  function automatic int lead(int g, int i);
    if (g == 1) begin
      if (i == 0) return 0; else if (i <= 2) return 1; else if (i <= 4) return 3; else return 5;
    end
    if (g == 2) begin
      if (i == 0) return 0; else if (i <= 3) return 1; else return 4;
    end
    if (g == 3) return 1;
    return i;
  endfunction

  task automatic model_step();
    logic [W-1:0] nv [NCH];
    bit ev [NCH];
    for (int j = 0; j < NCH; j++) begin
      bit hit;
      hit = wr_en && (int'(wr_sel) == j);
      nv[j] = hit ? wr_data : reg_m[j];
      case (ld_sel[2*j +: 2])
        2'd0: ev[j] = hit;
        2'd1: ev[j] = cnt_zero;
        2'd2: ev[j] = cnt_zero || (updown && cnt_period);
        default: ev[j] = (cnt_value == lat_m[j]);
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (ev[lead(int'(grp_sel), i)]) lat_m[i] = nv[i];
      reg_m[i] = nv[i];
    end
  endtask

  task automatic check(string tag);
    bit bad;
    bad = 0;
    checks++;
    for (int i = 0; i < NCH; i++) begin
      if (!bad && latch_o[i*W +: W] !== lat_m[i]) begin
        bad = 1;
        fails++;
        $display("FAIL %s ch%0d actual=%h expected=%h", tag, i, latch_o[i*W +: W], lat_m[i]);
      end
    end
  endtask

  function automatic logic [W-1:0] rdata();
    if ($urandom_range(0, 3) == 0) return W'($urandom);
    return W'($urandom_range(0, 15));
  endfunction

  // mode < 0: random codes; ud < 0: random mode; zmode 0 never, 1 random, 2 always
  task automatic run_phase(string tag, int n, int g, int mode, int ud, int zmode);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(tag);
      grp_sel = 2'(g);
      for (int j = 0; j < NCH; j++)
        ld_sel[2*j +: 2] = (mode < 0) ? 2'($urandom_range(0, 3)) : 2'(mode);
      updown     = (ud < 0) ? 1'($urandom_range(0, 1)) : 1'(ud);
      cnt_zero   = (zmode == 2) ? 1'b1 : (zmode == 1) ? ($urandom_range(0, 4) == 0) : 1'b0;
      cnt_period = ($urandom_range(0, 2) == 0);
      wr_en      = (zmode == 2) ? 1'b1 : ($urandom_range(0, 1) == 1);
      wr_sel     = 3'($urandom_range(0, NCH - 1));
      wr_data    = rdata();
      if ($urandom_range(0, 1) == 1) cnt_value = lat_m[$urandom_range(0, NCH - 1)];
      else cnt_value = rdata();
      @(posedge clk);
      model_step();
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin reg_m[i] = '0; lat_m[i] = '0; end
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; ld_sel = 0; grp_sel = 0;
    updown = 0; cnt_zero = 0; cnt_period = 0; cnt_value = 16'h1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset");
    rst = 1'b0;
    run_phase("R2 load on write",        150, 0, 0, -1, 1);
    run_phase("R3 load at zero",         150, 0, 1, -1, 1);
    run_phase("R4 ends, up count",       150, 0, 2,  0, 1);
    run_phase("R5 ends, up/down",        150, 0, 2,  1, 1);
    run_phase("R6 load on match",        200, 0, 3, -1, 1);
    run_phase("R11 no event hold",       150, 0, 1, -1, 0);
    run_phase("R12 write with load",     100, 0, 1, -1, 2);
    run_phase("R7 independent",          300, 0, -1, -1, 1);
    run_phase("R8 pairs",                300, 1, -1, -1, 1);
    run_phase("R9 triplets",             300, 2, -1, -1, 1);
    run_phase("R10 all channels",        300, 3, -1, -1, 1);
    run_phase("R10 all, match leader",   200, 3, 3, -1, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule